// File: doc/BRIEF.md
# Modem Control and Status Unit with Loopback

This block holds the modem-control byte and produces the modem-status byte of a 16550-class serial controller. The control byte drives four handshake outputs (DTR, RTS, OUT1, OUT2) and a loopback switch. The status byte shows two things: the present level of each of the four handshake inputs (CTS, DSR, RI, DCD), and a sticky change flag for each input. A CPU read of the status byte clears the change flags. Any set flag raises a modem-status interrupt request. Interrupt arbitration happens elsewhere.

External handshake inputs pass through a synchroniser before the block looks for changes. The loopback switch has three effects. It wraps the transmit shift output onto the receiver's serial input. It parks the serial output pin at the idle (high) level. It forces the four handshake outputs inactive and feeds the control bits back into the status levels, so driver software can test both paths without a cable.

The reset input `rst_n` is assumed to be already released synchronously to `clk` by the surrounding chip.

Top module: `uart_modem_ctl`

## Requirements
- R1: The control byte resets to 0x00. A write strobe stores bits 4..0: DTR in bit 0, RTS in bit 1, OUT1 in bit 2, OUT2 in bit 3 and loopback in bit 4. Read-back bits 7..5 are always 0.
- R2: Outside loopback, `dtr_o`, `rts_o`, `out1_o` and `out2_o` equal control bits 0, 1, 2 and 3, with 1 meaning asserted. They follow a write from the clock edge that stores it.
- R3: Status bits 4..7 give the levels of CTS, DSR, RI and DCD (1 = asserted). An external pin change appears there SYNC_STAGES clock edges after it is applied.
- R4: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) set one edge after the matching level in bits 4..7 changes in either direction. Status bit 2 sets only when RI goes from 1 to 0.
- R5: A set change bit stays set until a status read strobe. The status read clears bits 0..3 at the edge that ends the read cycle.
- R6: A change detected in the same cycle as a status read leaves its change bit set after that read.
- R7: `msi_req_o` is high exactly when any of status bits 0..3 is set.
- R8: Outside loopback, `sout_o` follows `tx_sdata` and `rx_sin_o` follows `ext_sin`. In loopback, `sout_o` is 1, `rx_sin_o` follows `tx_sdata`, and `ext_sin` has no effect.
- R9: In loopback, status bits 4, 5, 6 and 7 show RTS, DTR, OUT1 and OUT2 from the control byte. The external CTS, DSR, RI and DCD pins have no effect on the status byte.
- R10: In loopback, `dtr_o`, `rts_o`, `out1_o` and `out2_o` are all 0, whatever the control bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read-back |
| sts_rd | input | 1 | Status byte read strobe (clears change bits) |
| sts_rdata | output | 8 | Status byte: levels in 7..4, change flags in 3..0 |
| cts_i | input | 1 | Clear-to-send input, 1 = asserted |
| dsr_i | input | 1 | Data-set-ready input, 1 = asserted |
| ri_i | input | 1 | Ring-indicator input, 1 = asserted |
| dcd_i | input | 1 | Carrier-detect input, 1 = asserted |
| tx_sdata | input | 1 | Serial output of the transmit shifter |
| ext_sin | input | 1 | External serial input pin |
| dtr_o | output | 1 | Data-terminal-ready output, 1 = asserted |
| rts_o | output | 1 | Request-to-send output, 1 = asserted |
| out1_o | output | 1 | User output 1, 1 = asserted |
| out2_o | output | 1 | User output 2, 1 = asserted |
| sout_o | output | 1 | Serial output pin |
| rx_sin_o | output | 1 | Serial input routed to the receiver |
| msi_req_o | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that value, the latency from a pin change to the level bit (two edges) and to the change bit (three edges) are fixed numbers that the bench checks exactly. It also makes the same-cycle read race easy to hit: the bench holds the read strobe in the single cycle where a synchronised level differs from its stored copy. Loopback is driven through every control pattern that moves the wrapped levels, including RI rising (must not flag) and leaving loopback while the external pins are high.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int MODEM_LINES = 4;
  localparam int CTL_BITS    = 5;

  // Control byte, bit 4 (loop) down to bit 0 (dtr).
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mctl_t;

  // Line levels, bit 3 (dcd) down to bit 0 (cts).
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta
  import uart_modem_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  mline_t                 lvl,
  input  logic                   clr_rd,
  output logic [MODEM_LINES-1:0] delta
);
  mline_t                 prev_q;
  logic [MODEM_LINES-1:0] delta_q, delta_d, set_v, chg;

  always_comb begin
    chg      = lvl ^ prev_q;
    set_v    = chg;
    // Ring change flags only on the trailing edge.
    set_v[2] = prev_q.ri & ~lvl.ri;
    // A set in the read cycle wins over the clear.
    delta_d  = (delta_q & ~{MODEM_LINES{clr_rd}}) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= lvl;
      delta_q <= delta_d;
    end
  end

  assign delta = delta_q;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       tx_sdata,
  input  logic       ext_sin,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       sout_o,
  output logic       rx_sin_o,
  output logic       msi_req_o
);
  localparam int RSVD_BITS = 8 - CTL_BITS;

  mctl_t                  ctl_q, ctl_d;
  mline_t                 ext_raw, ext_sync, lvl;
  logic [MODEM_LINES-1:0] delta;
  logic [RSVD_BITS-1:0]   unused_rsvd;

  assign unused_rsvd = ctl_wdata[7:CTL_BITS];

  // Control register: next state, then register with explicit enable.
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = mctl_t'(ctl_wdata[CTL_BITS-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_rdata = {{RSVD_BITS{1'b0}}, ctl_q};

  // Handshake outputs, parked inactive in loopback.
  always_comb begin
    dtr_o  = ctl_q.dtr  & ~ctl_q.loop;
    rts_o  = ctl_q.rts  & ~ctl_q.loop;
    out1_o = ctl_q.out1 & ~ctl_q.loop;
    out2_o = ctl_q.out2 & ~ctl_q.loop;
  end

  // Serial wrap.
  assign sout_o   = ctl_q.loop ? 1'b1     : tx_sdata;
  assign rx_sin_o = ctl_q.loop ? tx_sdata : ext_sin;

  // Input synchroniser.
  assign ext_raw = '{dcd: dcd_i, ri: ri_i, dsr: dsr_i, cts: cts_i};

  modem_sync #(.WIDTH(MODEM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_raw),
    .q     (ext_sync)
  );

  // Level source: external pins or wrapped control bits.
  always_comb begin
    if (ctl_q.loop)
      lvl = '{dcd: ctl_q.out2, ri: ctl_q.out1, dsr: ctl_q.dtr, cts: ctl_q.rts};
    else
      lvl = ext_sync;
  end

  modem_delta u_delta (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (lvl),
    .clr_rd (sts_rd),
    .delta  (delta)
  );

  assign sts_rdata = {lvl, delta};
  assign msi_req_o = |delta;
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_rdata,
  input logic       sts_rd,
  input logic [7:0] sts_rdata,
  input logic       tx_sdata,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       out1_o,
  input logic       out2_o,
  input logic       sout_o,
  input logic       rx_sin_o,
  input logic       msi_req_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7:5] == 3'b000); // R1

  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req_o && !sts_rd) |=> msi_req_o); // R5

  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req_o == (|sts_rdata[3:0])); // R7

  AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |-> (sout_o && rx_sin_o == tx_sdata)); // R8

  AST_LOOP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |-> sts_rdata[7:4] ==
      {ctl_rdata[3], ctl_rdata[2], ctl_rdata[0], ctl_rdata[1]}); // R9

  AST_LOOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |-> !(dtr_o || rts_o || out1_o || out2_o)); // R10
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_rdata (ctl_rdata),
  .sts_rd    (sts_rd),
  .sts_rdata (sts_rdata),
  .tx_sdata  (tx_sdata),
  .dtr_o     (dtr_o),
  .rts_o     (rts_o),
  .out1_o    (out1_o),
  .out2_o    (out2_o),
  .sout_o    (sout_o),
  .rx_sin_o  (rx_sin_o),
  .msi_req_o (msi_req_o)
);

// File: tb/uart_modem_ctl_test.sv
`timescale 1ns/1ps
module uart_modem_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       sts_rd = 1'b0;
  logic [7:0] sts_rdata;
  logic       cts_i = 1'b0, dsr_i = 1'b0, ri_i = 1'b0, dcd_i = 1'b0;
  logic       tx_sdata = 1'b1, ext_sin = 1'b1;
  logic       dtr_o, rts_o, out1_o, out2_o, sout_o, rx_sin_o, msi_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_modem_ctl #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
    .tx_sdata(tx_sdata), .ext_sin(ext_sin),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .sout_o(sout_o), .rx_sin_o(rx_sin_o), .msi_req_o(msi_req_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_sts(input string tag, input logic [7:0] exp);
    sts_rd = 1'b1;
    chk(tag, sts_rdata, exp);
    tick(1);
    sts_rd = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {4'h0, out2_o, out1_o, rts_o, dtr_o};
  endfunction

  task automatic t_reset();
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset ctl", ctl_rdata, 8'h00);
    chk("R3 reset sts", sts_rdata, 8'h00);
    chk("R7 reset irq", {7'd0, msi_req_o}, 8'h00);
    chk("R2 reset outs", outs(), 8'h00);
  endtask

  task automatic t_ctl();
    wr_ctl(8'hEF);
    chk("R1 ctl readback", ctl_rdata, 8'h0F);
    chk("R2 outs all on", outs(), 8'h0F);
    wr_ctl(8'hE5);
    chk("R2 outs dtr out1", outs(), 8'h05);
    chk("R3 sts untouched", sts_rdata, 8'h00);
    wr_ctl(8'h00);
  endtask

  task automatic t_levels();
    cts_i = 1'b1;
    tick(1);
    chk("R3 one edge not yet", sts_rdata, 8'h00);
    tick(1);
    chk("R3 level after sync", sts_rdata, 8'h10);
    tick(1);
    chk("R4 cts rise flag", sts_rdata, 8'h11);
    chk("R7 irq on", {7'd0, msi_req_o}, 8'h01);
    rd_sts("R5 read value", 8'h11);
    chk("R5 cleared by read", sts_rdata, 8'h10);
    chk("R7 irq off", {7'd0, msi_req_o}, 8'h00);
    cts_i = 1'b0; dsr_i = 1'b1; dcd_i = 1'b1;
    tick(8);
    chk("R5 held without read", sts_rdata, 8'hAB);
    rd_sts("R4 multi flags", 8'hAB);
    chk("R5 multi cleared", sts_rdata, 8'hA0);
    dsr_i = 1'b0; dcd_i = 1'b0;
    tick(3);
    chk("R4 falls flagged", sts_rdata, 8'h0A);
    rd_sts("R5 clear falls", 8'h0A);
  endtask

  task automatic t_ri();
    ri_i = 1'b1;
    tick(3);
    chk("R4 ri rise no flag", sts_rdata, 8'h40);
    chk("R7 irq stays low", {7'd0, msi_req_o}, 8'h00);
    ri_i = 1'b0;
    tick(3);
    chk("R4 ri trailing flag", sts_rdata, 8'h04);
    rd_sts("R5 clear ri", 8'h04);
  endtask

  task automatic t_same_cycle();
    cts_i = 1'b1;
    tick(2);
    rd_sts("R6 read during change", 8'h10);
    chk("R6 change kept", sts_rdata, 8'h11);
    rd_sts("R6 later clear", 8'h11);
    cts_i = 1'b0;
    tick(3);
    rd_sts("R6 tidy", 8'h01);
  endtask

  task automatic t_loop_serial();
    tx_sdata = 1'b0; ext_sin = 1'b1;
    tick(1);
    chk("R8 normal sout", {7'd0, sout_o}, 8'h00);
    chk("R8 normal rx", {7'd0, rx_sin_o}, 8'h01);
    wr_ctl(8'h10);
    chk("R8 loop sout high", {7'd0, sout_o}, 8'h01);
    chk("R8 loop rx tx0", {7'd0, rx_sin_o}, 8'h00);
    tx_sdata = 1'b1; ext_sin = 1'b0;
    tick(1);
    chk("R8 loop rx tx1", {7'd0, rx_sin_o}, 8'h01);
    chk("R8 loop sout stays", {7'd0, sout_o}, 8'h01);
  endtask

  task automatic t_loop_status();
    cts_i = 1'b1; dsr_i = 1'b1; ri_i = 1'b1; dcd_i = 1'b1;
    tick(4);
    chk("R9 pins ignored", sts_rdata, 8'h00);
    wr_ctl(8'h12);
    chk("R9 rts to cts level", sts_rdata, 8'h10);
    chk("R10 rts parked", outs(), 8'h00);
    tick(1);
    rd_sts("R9 cts flag", 8'h11);
    wr_ctl(8'h1D);
    chk("R10 outs parked", outs(), 8'h00);
    tick(1);
    chk("R9 wrapped levels", sts_rdata, 8'hEB);
    rd_sts("R9 clear", 8'hEB);
    wr_ctl(8'h00);
    tick(1);
    chk("R9 leave loop ext high", sts_rdata, 8'hF1);
    chk("R8 sout follows tx", {7'd0, sout_o}, {7'd0, tx_sdata});
    chk("R2 outs after loop", outs(), 8'h00);
  endtask

  initial begin
    t_reset();
    t_ctl();
    t_levels();
    t_ri();
    t_same_cycle();
    t_loop_serial();
    t_loop_status();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule